// File: doc/BRIEF.md
# Differential PSK Symbol Mapper

This block turns small groups of raw data bits into unfiltered I/Q constellation points, one point for each accepted symbol. It has three modulation modes. Two of them, pi/4-QPSK and 3pi/8-rotated 8-PSK, use a constellation that turns a fixed angle on every symbol. The third, plain 8-PSK, uses a constellation that does not turn. The block keeps a running phase, counted in steps of pi/8, and adds the angle that the symbol's bits select.

Each output point is a pair of signed 16-bit Q1.15 values with a one-cycle valid strobe. The points come out at the symbol rate and go to a later interpolating filter. They are not meant to drive the signal path directly. A synchronous clear sets the running phase back to zero, so that a new burst starts from a known phase.

Top module: `dpsk_point_mapper`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `out_i` and `out_q` become 0 and the running phase becomes 0.
- R2: A symbol is accepted at a clock edge where `sym_valid` is 1 and `clear` is 0. In that case `out_valid` is 1 during the following cycle. Each accepted symbol gives exactly one point.
- R3: After an edge where no symbol is accepted, `out_valid` is 0, `out_i` and `out_q` keep their values, and the running phase does not change.
- R4: The bits are Gray-decoded. For three bits b2 b1 b0 the value is g = {b2, b2^b1, b2^b1^b0}. In pi/4-QPSK mode only `sym_bits[1:0]` are used, so g = {b1, b1^b0}, and `sym_bits[2]` has no effect.
- R5: Each accepted symbol has a rotation rot and an offset off, both set by the mode. The point index is (phase + rot + off) mod 16. The running phase becomes (phase + rot) mod 16.
- R6: `mode` = 0 selects pi/4-QPSK: rot = 2 and off = 4g + 2. This gives quadrant angles of 1, 3, 5 or 7 times pi/4 on a frame that turns pi/4 per symbol.
- R7: `mode` = 1 selects plain 8-PSK: rot = 0 and off = 2g. `mode` = 3 behaves exactly like `mode` = 1.
- R8: `mode` = 2 selects 3pi/8-rotated 8-PSK: rot = 3 and off = 2g.
- R9: For point index k, `out_i` = round(A·cos(k·pi/8)) and `out_q` = round(A·sin(k·pi/8)), with A = 32768/sqrt(2) (about 0.7071 of full scale).
- R10: An edge with `clear` high sets the running phase to 0. A symbol presented at that same edge is dropped: `out_valid` is 0 in the next cycle and `out_i`/`out_q` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Synchronous clear of the running phase; a symbol at the same edge is dropped |
| mode | input | 2 | 0 pi/4-QPSK, 1 8-PSK, 2 3pi/8-rotated 8-PSK, 3 same as 1 |
| sym_valid | input | 1 | A symbol is present on `sym_bits` |
| sym_bits | input | 3 | Data bits of the symbol (bit 2 is unused in pi/4-QPSK) |
| out_valid | output | 1 | A new point is on `out_i`/`out_q` |
| out_i | output | 16 | In-phase value, signed Q1.15 |
| out_q | output | 16 | Quadrature value, signed Q1.15 |

## Verification
The assertions assume that `mode` and `sym_bits` have known values whenever `sym_valid` is high. They also assume that `rst_n` is held low for at least one edge before any symbol arrives, so that the phase checks start from a defined value. The stimulus drives every input only at the falling clock edge and keeps all of them at defined levels from time zero. It sweeps every mode against every 3-bit value several times while the phase keeps running. It also mixes in idle cycles, mode changes in the middle of a stream, and clears that arrive together with a symbol.

// File: rtl/dpsk_pkg.sv
// Package dpsk_pkg
// Shared widths, the mode encoding and the Gray decode for the PSK point mapper.
// Assumes a 16-step phase circle (pi/8 per step) and 16-bit signed samples.
package dpsk_pkg;
    localparam int PH_W   = 4;   // phase accumulator width, pi/8 units
    localparam int BITS_W = 3;   // widest symbol (8-PSK)
    localparam int SMP_W  = 16;  // Q1.15 sample width

    typedef enum logic [1:0] {
        MODE_QPSK_PI4 = 2'd0,
        MODE_PSK8     = 2'd1,
        MODE_PSK8_ROT = 2'd2,
        MODE_PSK8_ALT = 2'd3
    } psk_mode_e;

    // Gray code to binary, 3 bits
    function automatic logic [BITS_W-1:0] gray_to_bin(input logic [BITS_W-1:0] gv);
        logic [BITS_W-1:0] bv;
        bv[BITS_W-1] = gv[BITS_W-1];
        for (int n = BITS_W - 2; n >= 0; n--) begin
            bv[n] = bv[n+1] ^ gv[n];
        end
        return bv;
    endfunction
endpackage

// File: rtl/dpsk_phase_ctrl.sv
// Module dpsk_phase_ctrl
// Holds the running phase and, for each symbol, works out the point index from
// the mode's rotation and the Gray-decoded data offset. The index is
// combinational and is valid in the cycle the symbol is presented.
// Assumes: mode and sym_bits are known whenever sym_valid is high.
module dpsk_phase_ctrl
    import dpsk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [1:0]        mode,
    input  logic              sym_valid,
    input  logic [BITS_W-1:0] sym_bits,
    output logic              pt_fire,
    output logic [PH_W-1:0]   pt_idx
);
    logic [PH_W-1:0]   phase_q;
    logic [PH_W-1:0]   rot;
    logic [PH_W-1:0]   off;
    logic [BITS_W-1:0] g3;
    logic [1:0]        g2;

    // Decode the data bits and pick this mode's rotation and offset
    always_comb begin
        g3 = gray_to_bin(sym_bits);
        g2 = {sym_bits[1], sym_bits[1] ^ sym_bits[0]};
        case (psk_mode_e'(mode))
            MODE_QPSK_PI4: begin
                rot = PH_W'(2);
                off = {g2, 2'b10};
            end
            MODE_PSK8_ROT: begin
                rot = PH_W'(3);
                off = {g3, 1'b0};
            end
            default: begin
                rot = '0;
                off = {g3, 1'b0};
            end
        endcase
    end

    // A symbol is accepted only when no clear is pending
    always_comb begin
        pt_fire = sym_valid & ~clear;
        pt_idx  = phase_q + rot + off;
    end

    // Running phase: reset and clear to zero, advance on each accepted symbol
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            phase_q <= '0;
        end else if (sym_valid) begin
            phase_q <= phase_q + rot;
        end
    end

    a_r10_clear_zeroes_phase: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (phase_q == '0));

    a_r3_idle_keeps_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (!sym_valid && !clear) |=> $stable(phase_q));

    a_r7_plain_psk8_no_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_fire && mode[0]) |=> $stable(phase_q));

    a_r6_qpsk_turns_two: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_fire && mode == 2'd0) |=> (phase_q == $past(phase_q) + PH_W'(2)));

    a_r8_rot_turns_three: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_fire && mode == 2'd2) |=> (phase_q == $past(phase_q) + PH_W'(3)));
endmodule

// File: rtl/dpsk_trig_lut.sv
// Module dpsk_trig_lut
// Turns a 16-step phase index into cosine and sine at amplitude 32768/sqrt(2).
// Only five quarter-wave magnitudes are stored; quadrant folding gives the rest.
// Assumes a 4-bit index and 16-bit output.
module dpsk_trig_lut
    import dpsk_pkg::*;
(
    input  logic [PH_W-1:0]          idx,
    output logic signed [SMP_W-1:0]  cos_o,
    output logic signed [SMP_W-1:0]  sin_o
);
    // Quarter-wave magnitude for steps 0..4 of pi/8
    function automatic logic signed [SMP_W-1:0] quarter_mag(input logic [2:0] s);
        case (s)
            3'd0:    return 16'sd23170;
            3'd1:    return 16'sd21407;
            3'd2:    return 16'sd16384;
            3'd3:    return 16'sd8867;
            default: return 16'sd0;
        endcase
    endfunction

    // Cosine of k*pi/8 by folding into the first quadrant
    function automatic logic signed [SMP_W-1:0] fold_cos(input logic [PH_W-1:0] k);
        logic [2:0] r;
        logic [2:0] rr;
        r  = {1'b0, k[1:0]};
        rr = 3'd4 - r;
        case (k[3:2])
            2'd0:    return  quarter_mag(r);
            2'd1:    return -quarter_mag(rr);
            2'd2:    return -quarter_mag(r);
            default: return  quarter_mag(rr);
        endcase
    endfunction

    // sin(x) = cos(x - pi/2), a shift of four steps
    always_comb begin
        cos_o = fold_cos(idx);
        sin_o = fold_cos(idx + PH_W'(12));
    end

    // Every point lies on the circle of radius A, within rounding
    always_comb begin
        a_r9_on_circle: assert ((32'(cos_o) * 32'(cos_o) + 32'(sin_o) * 32'(sin_o)) >= 32'sd536800000
                             && (32'(cos_o) * 32'(cos_o) + 32'(sin_o) * 32'(sin_o)) <= 32'sd536950000);
    end
endmodule

// File: rtl/dpsk_point_mapper.sv
// Module dpsk_point_mapper (top)
// Differential PSK symbol mapper: one registered I/Q point per accepted symbol,
// one cycle after it is presented. Outputs hold between points.
// Assumes: rst_n is held low for at least one edge before symbols arrive.
module dpsk_point_mapper
    import dpsk_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic [1:0]               mode,
    input  logic                     sym_valid,
    input  logic [2:0]               sym_bits,
    output logic                     out_valid,
    output logic signed [15:0]       out_i,
    output logic signed [15:0]       out_q
);
    logic                     pt_fire;
    logic [PH_W-1:0]          pt_idx;
    logic signed [SMP_W-1:0]  lut_cos;
    logic signed [SMP_W-1:0]  lut_sin;

    dpsk_phase_ctrl u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .mode      (mode),
        .sym_valid (sym_valid),
        .sym_bits  (sym_bits),
        .pt_fire   (pt_fire),
        .pt_idx    (pt_idx)
    );

    dpsk_trig_lut u_lut (
        .idx   (pt_idx),
        .cos_o (lut_cos),
        .sin_o (lut_sin)
    );

    // Output register: load a point on each accepted symbol, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= pt_fire;
            if (pt_fire) begin
                out_i <= lut_cos;
                out_q <= lut_sin;
            end
        end
    end

    a_r2_valid_follows_symbol: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && !clear) |=> out_valid);

    a_r10_clear_drops_symbol: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !out_valid);

    a_r3_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(sym_valid && !clear) |=> ($stable(out_i) && $stable(out_q) && !out_valid));
endmodule

// File: tb/sim_dpsk_point_mapper.sv
`timescale 1ns/1ps
module sim_dpsk_point_mapper;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               clear = 1'b0;
    logic [1:0]         mode = 2'd0;
    logic               sym_valid = 1'b0;
    logic [2:0]         sym_bits = 3'd0;
    logic               out_valid;
    logic signed [15:0] out_i;
    logic signed [15:0] out_q;

    int n_vec  = 0;
    int n_fail = 0;
    int m_phase = 0;
    int m_i = 0;
    int m_q = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dpsk_point_mapper u0 (
        .clk(clk), .rst_n(rst_n), .clear(clear), .mode(mode),
        .sym_valid(sym_valid), .sym_bits(sym_bits),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    function automatic int rnd(input real x);
        if (x >= 0.0) return $rtoi(x + 0.5);
        return -$rtoi(-x + 0.5);
    endfunction

    // R9: expected component at index k (trig=0 cosine, 1 sine)
    function automatic int ref_val(input int k, input int trig);
        real a;
        real ang;
        a   = 32768.0 * $sqrt(0.5);
        ang = 3.14159265358979 * real'(k) / 8.0;
        if (trig == 0) return rnd(a * $cos(ang));
        return rnd(a * $sin(ang));
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Present one cycle of stimulus at a falling edge, then check after the rise
    task automatic step(input bit v, input bit c, input logic [1:0] m, input int b);
        int g;
        int rot;
        int off;
        int k;
        bit exp_v;
        sym_valid = v;
        clear     = c;
        mode      = m;
        sym_bits  = 3'(b);
        exp_v = 1'b0;
        if (c) begin
            m_phase = 0;                                 // R10
        end else if (v) begin
            if (m == 2'd0) begin                         // R6, R4
                g   = (b & 3) ^ ((b & 3) >> 1);
                rot = 2;
                off = 4 * g + 2;
            end else begin                               // R7, R8, R4
                g   = b ^ (b >> 1) ^ (b >> 2);
                rot = (m == 2'd2) ? 3 : 0;
                off = 2 * g;
            end
            k       = (m_phase + rot + off) % 16;        // R5
            m_phase = (m_phase + rot) % 16;
            m_i     = ref_val(k, 0);
            m_q     = ref_val(k, 1);
            exp_v   = 1'b1;
        end
        @(negedge clk);
        if (c) begin
            check("R10 valid", int'(out_valid), 0);
            check("R10 hold i", int'(out_i), m_i);
        end else if (v) begin
            check("R2 valid", int'(out_valid), 1);
            check("R9/R5 i", int'(out_i), m_i);
            check("R9/R5 q", int'(out_q), m_q);
        end else begin
            check("R3 valid", int'(out_valid), int'(exp_v));
            check("R3 hold i", int'(out_i), m_i);
            check("R3 hold q", int'(out_q), m_q);
        end
    endtask

    initial begin
        int lfsr;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check("R1 valid", int'(out_valid), 0);
        check("R1 i", int'(out_i), 0);
        check("R1 q", int'(out_q), 0);
        rst_n = 1'b1;
        // R1: phase is zero after reset, visible through a rotated symbol
        step(1'b1, 1'b0, 2'd2, 0);
        check("R1 phase i", int'(out_i), ref_val(3, 0));
        // Sweep all modes against all bit values, phase running throughout
        for (int m = 0; m < 4; m++) begin
            for (int rep = 0; rep < 3; rep++) begin
                for (int b = 0; b < 8; b++) begin
                    step(1'b1, 1'b0, 2'(m), b);          // R6 R7 R8 R11
                end
            end
        end
        // R4: in QPSK, bit 2 has no effect on the point
        step(1'b1, 1'b1, 2'd0, 0);
        step(1'b1, 1'b0, 2'd0, 5);
        check("R4 qpsk bit2 i", int'(out_i), ref_val(8, 0));
        check("R4 qpsk bit2 q", int'(out_q), ref_val(8, 1));
        // R3: idle cycles hold outputs and phase
        step(1'b0, 1'b0, 2'd2, 7);
        step(1'b0, 1'b0, 2'd0, 3);
        step(1'b1, 1'b0, 2'd1, 0);
        // R10: clear alone, then clear together with a symbol
        step(1'b1, 1'b0, 2'd2, 6);
        step(1'b0, 1'b1, 2'd2, 0);
        step(1'b1, 1'b0, 2'd2, 0);
        check("R10 phase zero", int'(out_i), ref_val(3, 0));
        step(1'b1, 1'b0, 2'd2, 4);
        step(1'b1, 1'b1, 2'd2, 4);
        step(1'b1, 1'b0, 2'd1, 1);
        // Mixed pseudo-random stream with idles and clears
        lfsr = 32'h1ACE;
        for (int n = 0; n < 600; n++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
            step(((lfsr >> 3) & 3) != 0, ((lfsr >> 5) & 15) == 0,
                 2'((lfsr >> 7) & 3), (lfsr >> 9) & 7);
        end
        sym_valid = 1'b0;
        clear     = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule